// File: doc/BRIEF.md
# Serial EEPROM Word-Write Sequencer

This block sits on the host side of a three-wire serial EEPROM link. It writes one 16-bit word to the device and then waits for the device to report that it has finished. It takes a parallel address, a data word and a one-cycle start strobe. It builds the instruction frame and clocks it out on a divided serial clock. The frame is a leading 1, the write opcode 01, the address sent most significant bit first, then the data sent from D15 down to D0.

After the last data bit, the sequencer lowers chip select while the serial clock is low. That edge starts the device's self-timed programming. Chip select is held low for a fixed number of system clocks, then raised again so that the device's data-out pin shows its status: low while busy, high when ready. The status pin passes through a two-flop synchroniser before the sequencer looks at it. The sequencer ends with a one-cycle done pulse when it sees ready. If the device is still busy after a set number of polling cycles, it ends with a one-cycle timeout pulse instead.

The address width is a parameter: 6, 8 or 10 bits for the three array sizes. Any address bit the device ignores is sent exactly as given.

Top module: `eew_writer`

## Requirements
- R1: After reset, ee_cs, ee_sk, ee_di, busy, done and timeout_err are all 0.
- R2: A start strobe given while idle raises ee_cs and busy on the next clock. It produces exactly 3+AW+16 rising edges of ee_sk. At those edges ee_di carries, in order: 1, 0, 1, addr from its MSB down, then wdata from bit 15 down to bit 0.
- R3: ee_di does not change while ee_sk is high.
- R4: Every high phase and every low phase of ee_sk, including the first low phase after start, lasts exactly DIV_HALF system clocks.
- R5: ee_cs falls in the same clock in which ee_sk falls after the last data bit. No further ee_sk edge occurs before ee_cs falls.
- R6: ee_cs stays low for exactly CS_LOW_CYC system clocks and then rises to start polling.
- R7: While polling, ee_sk stays low. If ee_do goes high between clock edges k and k+1, counted from the edge that raised ee_cs, then done is high after edge k+3. At that same edge ee_cs drops and busy clears.
- R8: If ee_do stays low, timeout_err pulses after edge POLL_MAX (counted the same way), ee_cs drops, and done stays low.
- R9: A start strobe while busy is ignored. The frame on the wire is unchanged, and no second transfer follows.
- R10: done and timeout_err are single-cycle pulses and are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle request to write a word |
| addr | input | AW | Word address |
| wdata | input | 16 | Word to write |
| ee_do | input | 1 | Device data out (busy/ready status) |
| ee_cs | output | 1 | Device chip select |
| ee_sk | output | 1 | Device serial clock |
| ee_di | output | 1 | Device data in |
| busy | output | 1 | A write is in progress |
| done | output | 1 | Pulse: device reported ready |
| timeout_err | output | 1 | Pulse: polling gave up |

## Verification
The embedded assertions check the following on every cycle: data-in holds still while the serial clock is high, the serial clock is low when chip select falls and during polling, chip select is low throughout the hold phase, and done and timeout are exclusive single pulses. The bench's scenarios are the only way to show the following. It shows the exact bit order of the frame for every address of a 6-bit configuration and its clock phase lengths. It shows the exact length of the chip-select low window and the exact clock on which done follows a ready level that arrives after a varied delay. It also shows the timeout edge and the way a start strobe given mid-frame is ignored.

// File: rtl/eew_pkg.sv
package eew_pkg;
    localparam int WORD_W = 16;
    localparam logic [2:0] WR_HEAD = 3'b101;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_SHIFT = 2'd1,
        ST_CSLOW = 2'd2,
        ST_POLL  = 2'd3
    } eew_state_e;
endpackage

// File: rtl/eew_tick.sv
module eew_tick #(
    parameter int HALF = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int CW = $clog2(HALF) + 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == LAST);
        cnt_d = (!en || tick) ? '0 : cnt_q + CW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end
endmodule

// File: rtl/eew_sync2.sv
module eew_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    logic [1:0] ff_d, ff_q;

    always_comb ff_d = {ff_q[0], din};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ff_q <= '0;
        else        ff_q <= ff_d;
    end

    assign dout = ff_q[1];
endmodule

// File: rtl/eew_writer.sv
module eew_writer
    import eew_pkg::*;
#(
    parameter int AW         = 6,
    parameter int DIV_HALF   = 4,
    parameter int CS_LOW_CYC = 8,
    parameter int POLL_MAX   = 1000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [AW-1:0] addr,
    input  logic [15:0]   wdata,
    input  logic          ee_do,
    output logic          ee_cs,
    output logic          ee_sk,
    output logic          ee_di,
    output logic          busy,
    output logic          done,
    output logic          timeout_err
);
    localparam int FL      = 3 + AW + WORD_W;
    localparam int BW      = $clog2(FL) + 1;
    localparam int CMAX    = (POLL_MAX > CS_LOW_CYC) ? POLL_MAX : CS_LOW_CYC;
    localparam int CW      = $clog2(CMAX) + 1;
    localparam logic [BW-1:0] LAST_BIT = BW'(FL - 1);
    localparam logic [CW-1:0] CS_LAST  = CW'(CS_LOW_CYC - 1);
    localparam logic [CW-1:0] PL_LAST  = CW'(POLL_MAX - 1);
    localparam logic [CW-1:0] SETTLE   = CW'(2);

    typedef struct packed {
        eew_state_e    st;
        logic [FL-1:0] shreg;
        logic [BW-1:0] bitcnt;
        logic [CW-1:0] cnt;
        logic          cs;
        logic          sk;
        logic          di;
        logic          done;
        logic          err;
    } regs_t;

    regs_t r_d, r_q;
    logic  tick;
    logic  do_s;

    eew_tick #(.HALF(DIV_HALF)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (r_q.st == ST_SHIFT),
        .tick  (tick)
    );

    eew_sync2 u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ee_do),
        .dout  (do_s)
    );

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        r_d.err  = 1'b0;
        case (r_q.st)
            ST_IDLE: begin
                if (start) begin
                    r_d.st     = ST_SHIFT;
                    r_d.shreg  = {WR_HEAD, addr, wdata};
                    r_d.bitcnt = '0;
                    r_d.cs     = 1'b1;
                    r_d.sk     = 1'b0;
                    r_d.di     = WR_HEAD[2];
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (!r_q.sk) begin
                        r_d.sk = 1'b1;
                    end else begin
                        r_d.sk = 1'b0;
                        if (r_q.bitcnt == LAST_BIT) begin
                            r_d.cs  = 1'b0;
                            r_d.di  = 1'b0;
                            r_d.cnt = '0;
                            r_d.st  = ST_CSLOW;
                        end else begin
                            r_d.shreg  = r_q.shreg << 1;
                            r_d.di     = r_q.shreg[FL-2];
                            r_d.bitcnt = r_q.bitcnt + BW'(1);
                        end
                    end
                end
            end
            ST_CSLOW: begin
                if (r_q.cnt == CS_LAST) begin
                    r_d.cs  = 1'b1;
                    r_d.cnt = '0;
                    r_d.st  = ST_POLL;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            ST_POLL: begin
                if (r_q.cnt >= SETTLE && do_s) begin
                    r_d.done = 1'b1;
                    r_d.cs   = 1'b0;
                    r_d.st   = ST_IDLE;
                end else if (r_q.cnt == PL_LAST) begin
                    r_d.err  = 1'b1;
                    r_d.cs   = 1'b0;
                    r_d.st   = ST_IDLE;
                end else begin
                    r_d.cnt = r_q.cnt + CW'(1);
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, shreg: '0, bitcnt: '0, cnt: '0,
                     cs: 1'b0, sk: 1'b0, di: 1'b0, done: 1'b0, err: 1'b0};
        end else begin
            r_q <= r_d;
        end
    end

    assign ee_cs       = r_q.cs;
    assign ee_sk       = r_q.sk;
    assign ee_di       = r_q.di;
    assign busy        = (r_q.st != ST_IDLE);
    assign done        = r_q.done;
    assign timeout_err = r_q.err;

    assert_di_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.sk && $past(r_q.sk)) |-> $stable(r_q.di));

    assert_sk_low_at_cs_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(r_q.cs) |-> !r_q.sk);

    assert_cs_held_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CSLOW) |-> !r_q.cs);

    assert_sk_quiet_poll_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_POLL) |-> (!r_q.sk && r_q.cs));

    assert_sk_moves_only_shift_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(r_q.sk) |-> ($past(r_q.st) == ST_SHIFT));

    assert_pulse_exclusive_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(r_q.done && r_q.err));

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.done || r_q.err) |=> !(r_q.done || r_q.err));
endmodule

// File: tb/sim_eew_writer.sv
module sim_eew_writer;
    localparam int AW   = 6;
    localparam int DH   = 2;
    localparam int CSL  = 5;
    localparam int PMAX = 40;
    localparam int FL   = 3 + AW + 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [15:0]   wdata = '0;
    logic          ee_do = 1'b0;
    logic          ee_cs, ee_sk, ee_di, busy, done, timeout_err;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    eew_writer #(.AW(AW), .DIV_HALF(DH), .CS_LOW_CYC(CSL), .POLL_MAX(PMAX)) u0 (
        .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .wdata(wdata),
        .ee_do(ee_do), .ee_cs(ee_cs), .ee_sk(ee_sk), .ee_di(ee_di),
        .busy(busy), .done(done), .timeout_err(timeout_err)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic run_write(input logic [AW-1:0] a, input logic [15:0] d, input int rdy, input bit poke);
        int rises, run, cslow, idx, j;
        logic prev_sk;
        logic [FL-1:0] cap, exp_frame;
        exp_frame = {3'b101, a, d};
        @(negedge clk);
        addr = a; wdata = d; start = 1'b1; ee_do = 1'b0;
        @(negedge clk);
        start = 1'b0;
        chk(ee_cs && busy, "R2 cs/busy raised", {30'd0, ee_cs, busy}, 32'h3);
        prev_sk = 1'b0; run = 1; rises = 0; cap = '0; idx = 0;
        forever begin
            @(negedge clk);
            idx++;
            if (poke && idx == 10) begin start = 1'b1; addr = ~a; wdata = ~d; end
            if (poke && idx == 11) start = 1'b0;
            if (!ee_cs || idx > 2000) break;
            if (ee_sk != prev_sk) begin
                if (run != DH) chk(0, "R4 sk phase", run, DH);
                run = 1;
                if (ee_sk) begin rises++; cap = {cap[FL-2:0], ee_di}; end
            end else begin
                run++;
                if (ee_sk && ee_di != cap[0]) chk(0, "R3 di moved while sk high", ee_di, cap[0]);
            end
            prev_sk = ee_sk;
        end
        chk(ee_sk == 1'b0, "R5 sk low at cs fall", ee_sk, 0);
        chk(prev_sk == 1'b1 && run == DH, "R5 cs falls with last sk fall", run, DH);
        chk(rises == FL, "R2 rising edge count", rises, FL);
        chk(cap == exp_frame, poke ? "R9 frame kept despite start" : "R2 frame bits", cap, exp_frame);
        cslow = 1;
        forever begin
            @(negedge clk);
            if (ee_cs || cslow > 1000) break;
            cslow++;
        end
        chk(cslow == CSL, "R6 cs low length", cslow, CSL);
        j = 0;
        forever begin
            if (ee_sk) chk(0, "R7 sk moved during poll", ee_sk, 0);
            if (done != (rdy >= 0 && j == rdy + 3))
                chk(0, "R7 done timing", {j[30:0], done}, {j[30:0], 1'b0});
            if (timeout_err != (rdy < 0 && j == PMAX))
                chk(0, "R8 timeout timing", {j[30:0], timeout_err}, {j[30:0], 1'b0});
            if (done || timeout_err || j > PMAX + 4) break;
            if (rdy >= 0 && j == rdy) ee_do = 1'b1;
            @(negedge clk);
            j++;
        end
        if (rdy >= 0) begin
            chk(done && j == rdy + 3, "R7 done at expected edge", j, rdy + 3);
        end else begin
            chk(timeout_err && !done && j == PMAX, "R8 timeout at edge", j, PMAX);
        end
        chk(!ee_cs && !busy, "R7 cs/busy cleared at end", {30'd0, ee_cs, busy}, 0);
        @(negedge clk);
        chk(!done && !timeout_err && !busy && !ee_cs, "R10 single pulse and no rerun",
            {29'd0, done, timeout_err, busy}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done, timeout_err} == 6'b0, "R1 reset outputs",
            {ee_cs, ee_sk, ee_di, busy, done, timeout_err}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk({ee_cs, ee_sk, ee_di, busy, done, timeout_err} == 6'b0, "R1 idle after reset",
            {ee_cs, ee_sk, ee_di, busy, done, timeout_err}, 0);
        run_write(6'h00, 16'h0000, 0, 1'b0);
        run_write(6'h3F, 16'hFFFF, 2, 1'b0);
        for (int a = 0; a < 64; a++) begin
            logic [15:0] d;
            d = 16'(a * 16'h0403) ^ 16'hA5C3;
            if (a == 7 || a == 40) run_write(6'(a), d, -1, 1'b0);
            else                   run_write(6'(a), d, a % 9, (a % 5) == 1);
        end
        run_write(6'h15, 16'h8001, 4, 1'b1);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        int cyc = 0;
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 150000) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
                $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
                $finish;
            end
        end
    end
endmodule